// File: doc/BRIEF.md
# Serial EEPROM Boot Configuration Loader

This block is a small two-wire bus master that runs exactly once after each reset. It fetches a fixed-length run of configuration bytes from an external serial EEPROM and hands each byte, with its index, to a register file through a single-cycle write port. When the whole run has landed, a sticky completion flag rises. If the EEPROM fails to acknowledge its device address or the word address, the loader closes the bus with a STOP condition and raises a sticky error flag in place of completion.

The only transfer it ever makes is a sequential read. It first performs a dummy write that carries only the start word address. It then issues a repeated START, addresses the device for reading, and pulls in consecutive bytes. The device address is the fixed 7-bit value 7'b1010000, and only 7-bit addressing exists. Both bus lines are open-drain: each output is a drive-low enable, and a pull-up supplies the high level. While the synchronous reset is held, both enables stay off, so an external programmer can use the EEPROM freely. The byte count, start word address and SCL divider are compile-time parameters.

Top module: `cfg_loader_top`

## Requirements
- R1: While `rst` is high, on the cycle after every sampled reset edge, `scl_oe`, `sda_oe`, `done`, `err` and `wr_en` are all 0, so both lines are released.
- R2: During address and data bits, the SDA drive changes only while SCL is held low. The only SDA edges made while SCL is high are the START and STOP conditions, so a receiver sees exactly the intended START and STOP events.
- R3: The bus sequence is: START, 0xA0 (address 1010000 with the write bit 0), the word address START_ADDR, repeated START, 0xA1 (read bit 1), N_BYTES read bytes, STOP.
- R4: Every byte is shifted most significant bit first, both when sent and when received.
- R5: The master acknowledges each read byte except the last by driving SDA low in the ninth bit. It leaves SDA released (NACK) on the last byte and then issues STOP.
- R6: For read byte i (counting from 0), `wr_en` pulses for one cycle with `wr_addr` = i and `wr_data` = the EEPROM content at address START_ADDR + i (mod 256). There are exactly N_BYTES such pulses, and none after an error.
- R7: After the closing STOP of a successful load, `done` rises and stays high until reset. After that, both lines remain released and no further START occurs.
- R8: A NACK of 0xA0, of the word address, or of 0xA1 ends the transfer with a STOP, sets `err` and keeps it high until reset, leaves `done` at 0, and produces no write pulses. `done` and `err` are never both high.
- R9: After releasing SCL, the master waits until `scl_in` reads high before it advances the bit. A slave that holds SCL low therefore lengthens the bit without corrupting data.
- R10: With no clock stretching, consecutive falling edges of SCL inside a byte are exactly 4*CLK_DIV clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; releases the bus while high |
| scl_in | input | 1 | Sampled level of the SCL line |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wr_en | output | 1 | One-cycle write strobe to the register file |
| wr_addr | output | $clog2(N_BYTES) | Register file index of the byte being written |
| wr_data | output | 8 | Byte read from the EEPROM |
| done | output | 1 | Sticky: all bytes loaded |
| err | output | 1 | Sticky: address or word-address not acknowledged |

## Verification
Some properties are checked by assertions on every cycle. These cover the released bus during reset, SDA staying still while SCL is high inside a data bit, the wait for SCL to read high, the stickiness and exclusivity of `done` and `err`, and the absence of write strobes once the load has ended. Other properties can only be shown by the bench's scenarios, with an EEPROM model on the bus. These are the exact byte order on the wire, bit order, the ACK pattern with its final NACK, the loaded contents at each index, the abort paths for each of the three NACK points, behaviour under a stretched clock, and the measured SCL period.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

    localparam logic [6:0] EEPROM_DEV = 7'b1010000;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_BYTE  = 2'd2
    } line_op_e;

    typedef enum logic [3:0] {
        SQ_START,
        SQ_DEVW,
        SQ_WADDR,
        SQ_RSTART,
        SQ_DEVR,
        SQ_READ,
        SQ_STOP,
        SQ_FIN
    } seq_state_e;

    typedef struct packed {
        line_op_e   op;
        logic [7:0] data;
        logic       rd;   // byte is received rather than sent
        logic       ack;  // for received bytes: 1 = acknowledge (drive low)
    } line_cmd_t;

    function automatic logic [7:0] dev_byte(input logic rd);
        return {EEPROM_DEV, rd};
    endfunction

    function automatic line_cmd_t make_cmd(input seq_state_e st,
                                           input logic [7:0] word_addr,
                                           input logic       last);
        line_cmd_t c;
        c.op   = OP_BYTE;
        c.data = 8'h00;
        c.rd   = 1'b0;
        c.ack  = 1'b0;
        unique case (st)
            SQ_START, SQ_RSTART: c.op = OP_START;
            SQ_STOP:             c.op = OP_STOP;
            SQ_DEVW:             c.data = dev_byte(1'b0);
            SQ_WADDR:            c.data = word_addr;
            SQ_DEVR:             c.data = dev_byte(1'b1);
            SQ_READ: begin
                c.rd  = 1'b1;
                c.ack = !last;
            end
            default: c.op = OP_BYTE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cfg_ld_tick.sv
module cfg_ld_tick #(
    parameter int CLK_DIV = 125
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LIM = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cnt == LIM) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LIM);
endmodule

// File: rtl/cfg_ld_line.sv
module cfg_ld_line
    import cfg_ld_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      scl_in,
    input  logic      sda_in,
    input  logic      cmd_valid,
    input  line_cmd_t cmd,
    output logic      cmd_ready,
    output logic      op_done,
    output logic [7:0] rx_byte,
    output logic      ack_ok,
    output logic      scl_oe,
    output logic      sda_oe
);
    logic       busy;
    logic [1:0] phase;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    line_cmd_t  cur;
    logic       bit_drive;
    logic       step;

    assign cmd_ready = !busy;
    // phase 2 is the SCL-high sample point: advance only once SCL reads high
    assign step = busy && tick && (phase != 2'd2 || scl_in);

    always_comb begin
        if (cur.rd) bit_drive = (bitcnt == 4'd8) ? cur.ack : 1'b0;
        else        bit_drive = (bitcnt == 4'd8) ? 1'b0 : !shreg[7];
    end

    always_ff @(posedge clk) begin
        op_done <= 1'b0;
        if (rst) begin
            busy    <= 1'b0;
            phase   <= 2'd0;
            bitcnt  <= 4'd0;
            shreg   <= 8'h00;
            cur     <= '0;
            rx_byte <= 8'h00;
            ack_ok  <= 1'b0;
            scl_oe  <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (!busy) begin
            if (cmd_valid) begin
                busy   <= 1'b1;
                cur    <= cmd;
                shreg  <= cmd.data;
                phase  <= 2'd0;
                bitcnt <= 4'd0;
            end
        end else if (step) begin
            phase <= phase + 2'd1;
            unique case (cur.op)
                OP_START: begin
                    unique case (phase)
                        2'd0: sda_oe <= 1'b0;
                        2'd1: scl_oe <= 1'b0;
                        2'd2: sda_oe <= 1'b1;
                        default: begin
                            scl_oe  <= 1'b1;
                            busy    <= 1'b0;
                            op_done <= 1'b1;
                        end
                    endcase
                end
                OP_STOP: begin
                    unique case (phase)
                        2'd0: sda_oe <= 1'b1;
                        2'd1: scl_oe <= 1'b0;
                        2'd2: sda_oe <= 1'b0;
                        default: begin
                            busy    <= 1'b0;
                            op_done <= 1'b1;
                        end
                    endcase
                end
                default: begin
                    unique case (phase)
                        2'd0: sda_oe <= bit_drive;
                        2'd1: scl_oe <= 1'b0;
                        2'd2: begin
                            if (bitcnt == 4'd8) ack_ok <= !sda_in;
                            else                shreg  <= {shreg[6:0], sda_in};
                        end
                        default: begin
                            scl_oe <= 1'b1;
                            if (bitcnt == 4'd8) begin
                                busy    <= 1'b0;
                                op_done <= 1'b1;
                                rx_byte <= shreg;
                            end else begin
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    endcase
                end
            endcase
        end
    end

    // R2: inside a data bit, SDA drive holds still while SCL is released
    assert_sda_steady_scl_high_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy && cur.op == OP_BYTE && $past(cur.op) == OP_BYTE
         && !$past(scl_oe) && !scl_oe) |-> $stable(sda_oe));

    // R9: while the line is still held low externally, SCL stays released
    assert_scl_wait_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && phase == 2'd2 && !scl_oe && !scl_in) |=> !scl_oe);
endmodule

// File: rtl/cfg_ld_seq.sv
module cfg_ld_seq
    import cfg_ld_pkg::*;
#(
    parameter int         N_BYTES    = 16,
    parameter logic [7:0] START_ADDR = 8'h00,
    localparam int        IW         = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_ready,
    input  logic          op_done,
    input  logic [7:0]    rx_byte,
    input  logic          ack_ok,
    output logic          cmd_valid,
    output line_cmd_t     cmd,
    output logic          wr_en,
    output logic [IW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          done,
    output logic          err
);
    localparam logic [IW-1:0] LAST = IW'(N_BYTES - 1);

    seq_state_e    state;
    logic          issued;
    logic          failed;
    logic [IW-1:0] idx;

    assign cmd       = make_cmd(state, START_ADDR, idx == LAST);
    assign cmd_valid = !issued && state != SQ_FIN;

    always_ff @(posedge clk) begin
        wr_en <= 1'b0;
        if (rst) begin
            state   <= SQ_START;
            issued  <= 1'b0;
            failed  <= 1'b0;
            idx     <= '0;
            wr_addr <= '0;
            wr_data <= 8'h00;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            if (cmd_valid && cmd_ready) issued <= 1'b1;
            if (op_done) begin
                issued <= 1'b0;
                unique case (state)
                    SQ_START:  state <= SQ_DEVW;
                    SQ_RSTART: state <= SQ_DEVR;
                    SQ_DEVW, SQ_WADDR, SQ_DEVR: begin
                        if (!ack_ok) begin
                            failed <= 1'b1;
                            state  <= SQ_STOP;
                        end else if (state == SQ_DEVW)  state <= SQ_WADDR;
                        else if (state == SQ_WADDR)     state <= SQ_RSTART;
                        else                            state <= SQ_READ;
                    end
                    SQ_READ: begin
                        wr_en   <= 1'b1;
                        wr_addr <= idx;
                        wr_data <= rx_byte;
                        if (idx == LAST) state <= SQ_STOP;
                        else             idx   <= idx + 1'b1;
                    end
                    SQ_STOP: begin
                        state <= SQ_FIN;
                        done  <= !failed;
                        err   <= failed;
                    end
                    default: state <= SQ_FIN;
                endcase
            end
        end
    end

    // R7: completion is sticky until reset
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> done);
    // R8: error is sticky and never coexists with done
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        err |=> (err && !done));
    // R6: no register-file write once the load has ended
    assert_no_write_after_end_R6: assert property (@(posedge clk) disable iff (rst)
        (done || err) |-> !wr_en);
endmodule

// File: rtl/cfg_loader_top.sv
module cfg_loader_top
    import cfg_ld_pkg::*;
#(
    parameter int         N_BYTES    = 16,
    parameter logic [7:0] START_ADDR = 8'h00,
    parameter int         CLK_DIV    = 125,
    localparam int        IW         = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_oe,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [IW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          done,
    output logic          err
);
    logic      tick;
    logic      cmd_valid;
    logic      cmd_ready;
    line_cmd_t cmd;
    logic      op_done;
    logic [7:0] rx_byte;
    logic      ack_ok;

    cfg_ld_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    cfg_ld_line u_line (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .cmd_ready (cmd_ready),
        .op_done   (op_done),
        .rx_byte   (rx_byte),
        .ack_ok    (ack_ok),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    cfg_ld_seq #(.N_BYTES(N_BYTES), .START_ADDR(START_ADDR)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_ready (cmd_ready),
        .op_done   (op_done),
        .rx_byte   (rx_byte),
        .ack_ok    (ack_ok),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .done      (done),
        .err       (err)
    );

    // R1: a sampled reset leaves both lines and all flags released
    assert_bus_released_in_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (!scl_oe && !sda_oe && !done && !err && !wr_en));
endmodule

// File: tb/cfg_loader_top_test.sv
module cfg_loader_top_test;
    localparam int         N   = 5;
    localparam logic [7:0] SA  = 8'h30;
    localparam int         DIV = 4;
    localparam int         IW  = $clog2(N);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;  // 50 MHz

    logic scl_oe, sda_oe, wr_en, done, err;
    logic [IW-1:0] wr_addr;
    logic [7:0] wr_data;
    logic scl_bus, sda_bus;

    // bench-side bus model controls
    logic       nack_dw = 1'b0, nack_wa = 1'b0, nack_dr = 1'b0;
    logic [3:0] stretch = 4'd0;
    logic [3:0] rel_cnt;
    logic       sl;  // slave pulls SDA low

    assign scl_bus = !scl_oe && (rel_cnt >= stretch);
    assign sda_bus = !sda_oe && !sl;

    cfg_loader_top #(.N_BYTES(N), .START_ADDR(SA), .CLK_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done), .err(err)
    );

    function automatic logic [7:0] mem_val(input logic [7:0] a);
        return a * 8'd37 + 8'd11;
    endfunction

    // ---------------- EEPROM model and monitors (sample at negedge) -------
    typedef enum int { M_IDLE, M_RX, M_TX } mode_e;
    mode_e mode;
    int n_start, n_stop, n_recv, n_ack, n_wr, cyc, n_edge;
    logic [7:0] recv [8];
    logic       acks [16];
    logic [7:0] wdat [16];
    int         wadr [16];
    int         edge_t [4];
    logic ps, pd, first, acked, p_scl_oe;
    logic [7:0] shift, tx, ptr;
    int bitc;

    always @(negedge clk) begin
        logic s, d;
        s = scl_bus;
        d = sda_bus;
        cyc++;
        if (rst) begin
            mode = M_IDLE; n_start = 0; n_stop = 0; n_recv = 0; n_ack = 0;
            n_wr = 0; n_edge = 0; sl = 1'b0; bitc = 0; first = 1'b0;
            acked = 1'b0; shift = 8'h00; tx = 8'h00; ptr = 8'h00;
            rel_cnt = 4'd0; p_scl_oe = 1'b0;
        end else begin
            if (scl_oe) rel_cnt = 4'd0;
            else if (rel_cnt != 4'd15) rel_cnt = rel_cnt + 4'd1;
            if (scl_oe && !p_scl_oe && n_edge < 4) begin
                edge_t[n_edge] = cyc;
                n_edge++;
            end
            if (wr_en && n_wr < 16) begin
                wdat[n_wr] = wr_data;
                wadr[n_wr] = int'(wr_addr);
                n_wr++;
            end
            if (s && ps && pd && !d) begin
                n_start++; mode = M_RX; bitc = 0; sl = 1'b0; first = 1'b1;
            end else if (s && ps && !pd && d) begin
                n_stop++; mode = M_IDLE; sl = 1'b0;
            end else if (!ps && s) begin
                if (mode == M_RX && bitc < 8) shift = {shift[6:0], d};
                if (mode == M_TX && bitc == 8 && n_ack < 16) begin
                    acks[n_ack] = d;
                    n_ack++;
                end
                if (mode != M_IDLE) bitc++;
            end else if (ps && !s) begin
                if (mode == M_RX) begin
                    if (bitc == 8) begin
                        if (n_recv < 8) recv[n_recv] = shift;
                        n_recv++;
                        if (first && shift == 8'hA0)      acked = !nack_dw;
                        else if (first && shift == 8'hA1) acked = !nack_dr;
                        else if (!first)                  acked = !nack_wa;
                        else                              acked = 1'b0;
                        sl = acked;
                    end else if (bitc == 9) begin
                        sl = 1'b0;
                        bitc = 0;
                        if (!acked) mode = M_IDLE;
                        else if (first && shift == 8'hA1) begin
                            mode = M_TX; tx = mem_val(ptr);
                        end else if (first) first = 1'b0;
                        else begin
                            ptr = shift; mode = M_IDLE;
                        end
                    end
                end else if (mode == M_TX && bitc == 9) begin
                    bitc = 0;
                    if (!acks[n_ack-1]) begin
                        ptr = ptr + 8'd1; tx = mem_val(ptr);
                    end else begin
                        mode = M_IDLE; sl = 1'b0;
                    end
                end
                if (mode == M_TX) sl = (bitc < 8) ? !tx[7-bitc] : 1'b0;
            end
            ps = s;
            pd = d;
            p_scl_oe = scl_oe;
        end
        if (rst) begin
            ps = s;
            pd = d;
        end
    end

    // ---------------- checking ---------------------------------------------
    int tests = 0, fails = 0;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_end(output logic ok);
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done || err) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    typedef struct packed {
        logic       ndw;
        logic       nwa;
        logic       ndr;
        logic [3:0] str;
        logic       exp_done;
        logic [3:0] exp_starts;
        logic [3:0] exp_recv;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 4'd2, 4'd3},
        '{1'b0, 1'b0, 1'b0, 4'd6, 1'b1, 4'd2, 4'd3},
        '{1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 4'd1, 4'd1},
        '{1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 4'd1, 4'd2},
        '{1'b0, 1'b0, 1'b1, 4'd3, 1'b0, 4'd2, 4'd3}
    };

    initial begin
        logic ok;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!scl_oe && !sda_oe, "R1 lines released in reset", {scl_oe, sda_oe}, 0);
        check(!done && !err && !wr_en, "R1 flags clear in reset", {done, err, wr_en}, 0);

        foreach (VECS[v]) begin
            vec_t t;
            t = VECS[v];
            rst = 1'b1;
            nack_dw = t.ndw; nack_wa = t.nwa; nack_dr = t.ndr; stretch = t.str;
            do_reset();
            wait_end(ok);
            check(ok, "R7/R8 load ended", ok, 1);
            check(done == t.exp_done, "R7 done flag", done, t.exp_done);
            check(err == !t.exp_done, "R8 err flag", err, !t.exp_done);
            repeat (6 * DIV) @(negedge clk);
            check(n_stop == 1, "R3 single STOP", n_stop, 1);
            check(n_start == int'(t.exp_starts), "R2/R3 START count", n_start, t.exp_starts);
            check(n_recv == int'(t.exp_recv), "R3 bytes seen by EEPROM", n_recv, t.exp_recv);
            check(recv[0] == 8'hA0, "R3/R4 device write byte", recv[0], 8'hA0);
            if (t.exp_recv > 1)
                check(recv[1] == SA, "R3 word address", recv[1], SA);
            if (t.exp_recv > 2)
                check(recv[2] == 8'hA1, "R3/R4 device read byte", recv[2], 8'hA1);
            check(!scl_oe && !sda_oe, "R7 bus released at end", {scl_oe, sda_oe}, 0);
            if (t.exp_done) begin
                check(n_wr == N, "R6 write count", n_wr, N);
                check(n_ack == N, "R5 ack bits", n_ack, N);
                for (int i = 0; i < N; i++) begin
                    check(wadr[i] == i, "R6 write index", wadr[i], i);
                    check(wdat[i] == mem_val(SA + 8'(i)),
                          t.str != 0 ? "R9 data under stretching" : "R4/R6 write data",
                          wdat[i], mem_val(SA + 8'(i)));
                    check(acks[i] == (i == N - 1), "R5 ack/nack level", acks[i], i == N - 1);
                end
                if (t.str == 0)
                    check(edge_t[2] - edge_t[1] == 4 * DIV, "R10 SCL period",
                          edge_t[2] - edge_t[1], 4 * DIV);
            end else begin
                check(n_wr == 0, "R8 no writes after NACK", n_wr, 0);
            end
            repeat (200) @(negedge clk);
            check(n_start == int'(t.exp_starts), "R7 no restart after end", n_start, t.exp_starts);
            check(done == t.exp_done && err == !t.exp_done, "R7/R8 flags sticky",
                  {done, err}, {t.exp_done, !t.exp_done});
        end

        // R1: reset asserted mid-load releases the bus immediately
        nack_dw = 1'b0; nack_wa = 1'b0; nack_dr = 1'b0; stretch = 4'd0;
        do_reset();
        repeat (150) @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(!scl_oe && !sda_oe && !wr_en, "R1 release during mid-load reset",
                  {scl_oe, sda_oe, wr_en}, 0);
        end
        @(negedge clk);
        rst = 1'b0;
        wait_end(ok);
        check(done && !err, "R7 load completes after reset", {done, err}, 2);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule